// File: doc/BRIEF.md
# Four-Group Severity Interrupt Aggregator

This block gathers single-bit event inputs, split into groups, and records each event as a sticky cause bit in its own group's cause register. Each input bit can be captured either while the input is high or only on its rising edge. A per-source interrupt mask decides whether hardware may set that bit's cause at all. Software can also inject causes directly.

Software reaches the block through a 32-bit APB-style register port. Each group has its own copy of the register set, at byte address `group*0x40 + offset`. Cause bits stay set until software writes a 0 to their position; writing a 1 has no effect.

From its cause register, each group drives four registered summary lines: error, abort, fatal and log. Each line is the OR of the cause bits that its own mask leaves visible. A system can therefore send the same event to different handlers by severity, with no extra decoding.

Top module: `sev_irq_agg`

## Requirements
- R1: After reset, every cause bit and every summary output is 0. The interrupt mask (0x10) and the four severity masks (0x2C, 0x30, 0x34, 0x38) read all ones. The control word (0x28) reads 0x1 and the capture-mode register (0x3C) reads 0.
- R2: A bit in level mode (0x3C bit = 0) whose interrupt mask bit is 0 sets its cause bit at the first clock edge where its input is sampled high.
- R3: A bit in edge mode (0x3C bit = 1) sets its cause only when its input is high and its input at the previous clock edge was low. An input held high does not set the cause again after software clears it.
- R4: While a bit's interrupt mask (0x10) is 1, its input never sets its cause.
- R5: A write to the cause register (0x00) clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R6: Writing to the inject port (0x08) sets the cause bits written as 1. Bits written as 0 have no effect.
- R7: Writing to the unmask port (0x18) clears the interrupt-mask bits written as 0 and leaves the bits written as 1 unchanged. A write to 0x10 loads the mask directly.
- R8: The status register (0x20) returns the raw input value sampled at the previous clock edge, whatever the masks and the cause bits hold.
- R9: Each summary output of a group equals the OR of (cause AND NOT its severity mask), registered, so it follows a change of cause or mask by one clock cycle. Error uses 0x2C, abort 0x30, fatal 0x34 and log 0x38.
- R10: When a hardware set and a software clear reach the same cause bit at the same clock edge, the bit ends up set.
- R11: Register writes in one group (address bits above bit 5) change no register and no output of any other group.
- R12: Writes to the status register are ignored. The write-only ports 0x08 and 0x18 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address: group in bits above 5, offset in bits 5:0 |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data (combinational on paddr) |
| trig_i | input | NUM_GRP*GRP_W | Event inputs; group g occupies bits g*GRP_W upward |
| err_o | output | NUM_GRP | Error summary per group |
| abort_o | output | NUM_GRP | Abort summary per group |
| fatal_o | output | NUM_GRP | Fatal summary per group |
| log_o | output | NUM_GRP | Log summary per group |

## Verification
The bench builds the block with NUM_GRP=2, GRP_W=8 and ADDR_W=7. At this size it can walk every source bit of a group through injection, clearing, level capture and edge capture. It can also sweep each of the four severity masks bit by bit, and still use a second group to check address isolation. The narrow group width keeps every expected cause and summary value a small arithmetic expression in the bench. The cycle checks cover the same-edge collision of a hardware set and a software clear, and the one-cycle lag of the summary outputs.

// File: rtl/sia_pkg.sv
package sia_pkg;

   localparam logic [5:0] OFF_CAUSE  = 6'h00;
   localparam logic [5:0] OFF_INJECT = 6'h08;
   localparam logic [5:0] OFF_IMASK  = 6'h10;
   localparam logic [5:0] OFF_UNMASK = 6'h18;
   localparam logic [5:0] OFF_STATUS = 6'h20;
   localparam logic [5:0] OFF_CTRL   = 6'h28;
   localparam logic [5:0] OFF_SEVM0  = 6'h2C;
   localparam logic [5:0] OFF_EDGE   = 6'h3C;

   localparam int NUM_SEV = 4;

   typedef enum logic [1:0] {
      SEV_ERR   = 2'd0,
      SEV_ABORT = 2'd1,
      SEV_FATAL = 2'd2,
      SEV_LOG   = 2'd3
   } sev_e;

   typedef struct packed {
      logic        we;
      logic [5:0]  off;
      logic [31:0] wd;
   } reg_wr_t;

   function automatic logic [5:0] sev_mask_off(input int s);
      return OFF_SEVM0 + 6'(4 * s);
   endfunction

endpackage

// File: rtl/sia_capture.sv
module sia_capture #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] trig_i,
   input  logic [W-1:0] edge_sel_i,
   input  logic [W-1:0] imask_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] clr_keep_i,
   input  logic [W-1:0] sw_set_i,
   output logic [W-1:0] cause_o,
   output logic [W-1:0] samp_o,
   output logic [W-1:0] hw_set_o
);

   logic [W-1:0] prev_q;
   logic [W-1:0] cause_q;
   logic [W-1:0] fire;
   logic [W-1:0] kept;

   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         assign fire[b] = edge_sel_i[b] ? (trig_i[b] & ~prev_q[b]) : trig_i[b];
      end
   endgenerate

   assign hw_set_o = fire & ~imask_i;
   assign kept     = clr_we_i ? (cause_q & clr_keep_i) : cause_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         cause_q <= '0;
      end else begin
         prev_q  <= trig_i;
         cause_q <= kept | sw_set_i | hw_set_o;
      end
   end

   assign cause_o = cause_q;
   assign samp_o  = prev_q;

endmodule

// File: rtl/sia_group_regs.sv
module sia_group_regs
   import sia_pkg::*;
#(
   parameter int          W        = 32,
   parameter logic [31:0] CTRL_RST = 32'h1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  reg_wr_t                       wr_i,
   output logic [W-1:0]                  imask_o,
   output logic [W-1:0]                  edge_o,
   output logic [31:0]                   ctrl_o,
   output logic [NUM_SEV-1:0][W-1:0]     sevmask_o,
   output logic                          clr_we_o,
   output logic [W-1:0]                  sw_set_o
);

   logic [W-1:0] imask_q;
   logic [W-1:0] edge_q;
   logic [31:0]  ctrl_q;
   logic [W-1:0] wd_g;

   assign wd_g = wr_i.wd[W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imask_q <= '1;
         edge_q  <= '0;
         ctrl_q  <= CTRL_RST;
      end else if (wr_i.we) begin
         if (wr_i.off == OFF_IMASK)  imask_q <= wd_g;
         if (wr_i.off == OFF_UNMASK) imask_q <= imask_q & wd_g;
         if (wr_i.off == OFF_EDGE)   edge_q  <= wd_g;
         if (wr_i.off == OFF_CTRL)   ctrl_q  <= wr_i.wd;
      end
   end

   generate
      for (genvar s = 0; s < NUM_SEV; s++) begin : g_sevm
         logic [W-1:0] m_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               m_q <= '1;
            else if (wr_i.we && wr_i.off == sev_mask_off(s))
               m_q <= wd_g;
         end
         assign sevmask_o[s] = m_q;
      end
   endgenerate

   assign imask_o  = imask_q;
   assign edge_o   = edge_q;
   assign ctrl_o   = ctrl_q;
   assign clr_we_o = wr_i.we && (wr_i.off == OFF_CAUSE);
   assign sw_set_o = (wr_i.we && wr_i.off == OFF_INJECT) ? wd_g : '0;

endmodule

// File: rtl/sia_severity.sv
module sia_severity #(
   parameter int W    = 32,
   parameter int NSEV = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [W-1:0]               cause_i,
   input  logic [NSEV-1:0][W-1:0]     mask_i,
   output logic [NSEV-1:0]            sev_o
);

   generate
      for (genvar s = 0; s < NSEV; s++) begin : g_sev
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= |(cause_i & ~mask_i[s]);
         end
         assign sev_o[s] = q;
      end
   endgenerate

endmodule

// File: rtl/sev_irq_agg.sv
module sev_irq_agg
   import sia_pkg::*;
#(
   parameter int          NUM_GRP  = 4,
   parameter int          GRP_W    = 32,
   parameter int          ADDR_W   = 8,
   parameter logic [31:0] CTRL_RST = 32'h1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     psel,
   input  logic                     penable,
   input  logic                     pwrite,
   input  logic [ADDR_W-1:0]        paddr,
   input  logic [31:0]              pwdata,
   output logic [31:0]              prdata,
   input  logic [NUM_GRP*GRP_W-1:0] trig_i,
   output logic [NUM_GRP-1:0]       err_o,
   output logic [NUM_GRP-1:0]       abort_o,
   output logic [NUM_GRP-1:0]       fatal_o,
   output logic [NUM_GRP-1:0]       log_o
);

   localparam int GIDX_W  = ADDR_W - 6;
   localparam int MIN_AW  = 6 + ((NUM_GRP > 1) ? $clog2(NUM_GRP) : 1);

   generate
      if (GRP_W < 1 || GRP_W > 32) begin : g_bad_w
         $error("GRP_W must lie in 1..32");
      end
      if (NUM_GRP < 1) begin : g_bad_n
         $error("NUM_GRP must be at least 1");
      end
      if (ADDR_W < MIN_AW) begin : g_bad_a
         $error("ADDR_W too small for NUM_GRP groups at 0x40 stride");
      end
   endgenerate

   function automatic logic [31:0] widen(input logic [GRP_W-1:0] v);
      logic [31:0] r;
      r = '0;
      r[GRP_W-1:0] = v;
      return r;
   endfunction

   logic              wr_en;
   logic [GIDX_W-1:0] grp_idx;
   logic [5:0]        off;

   assign wr_en   = psel & penable & pwrite;
   assign grp_idx = paddr[ADDR_W-1:6];
   assign off     = paddr[5:0];

   logic [NUM_GRP-1:0][GRP_W-1:0] cause_all;
   logic [NUM_GRP-1:0][GRP_W-1:0] samp_all;
   logic [NUM_GRP-1:0][GRP_W-1:0] hw_set_all;
   logic [NUM_GRP-1:0][GRP_W-1:0] sw_set_all;
   logic [NUM_GRP-1:0][GRP_W-1:0] imask_all;
   logic [NUM_GRP-1:0][GRP_W-1:0] edge_all;
   logic [NUM_GRP-1:0][GRP_W-1:0] errmask_all;
   logic [31:0]                   rd_g [NUM_GRP];

   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
         reg_wr_t                        wr;
         logic                           clr_we;
         logic [31:0]                    ctrl;
         logic [NUM_SEV-1:0][GRP_W-1:0]  sevm;
         logic [NUM_SEV-1:0]             sev;

         assign wr.we  = wr_en && (grp_idx == GIDX_W'(g));
         assign wr.off = off;
         assign wr.wd  = pwdata;

         sia_group_regs #(
            .W        (GRP_W),
            .CTRL_RST (CTRL_RST)
         ) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (wr),
            .imask_o   (imask_all[g]),
            .edge_o    (edge_all[g]),
            .ctrl_o    (ctrl),
            .sevmask_o (sevm),
            .clr_we_o  (clr_we),
            .sw_set_o  (sw_set_all[g])
         );

         sia_capture #(
            .W (GRP_W)
         ) u_cap (
            .clk        (clk),
            .rst_n      (rst_n),
            .trig_i     (trig_i[g*GRP_W +: GRP_W]),
            .edge_sel_i (edge_all[g]),
            .imask_i    (imask_all[g]),
            .clr_we_i   (clr_we),
            .clr_keep_i (pwdata[GRP_W-1:0]),
            .sw_set_i   (sw_set_all[g]),
            .cause_o    (cause_all[g]),
            .samp_o     (samp_all[g]),
            .hw_set_o   (hw_set_all[g])
         );

         sia_severity #(
            .W    (GRP_W),
            .NSEV (NUM_SEV)
         ) u_sev (
            .clk     (clk),
            .rst_n   (rst_n),
            .cause_i (cause_all[g]),
            .mask_i  (sevm),
            .sev_o   (sev)
         );

         assign errmask_all[g] = sevm[SEV_ERR];
         assign err_o[g]   = sev[SEV_ERR];
         assign abort_o[g] = sev[SEV_ABORT];
         assign fatal_o[g] = sev[SEV_FATAL];
         assign log_o[g]   = sev[SEV_LOG];

         always_comb begin
            rd_g[g] = '0;
            case (off)
               OFF_CAUSE:              rd_g[g] = widen(cause_all[g]);
               OFF_IMASK:              rd_g[g] = widen(imask_all[g]);
               OFF_STATUS:             rd_g[g] = widen(samp_all[g]);
               OFF_CTRL:               rd_g[g] = ctrl;
               OFF_EDGE:               rd_g[g] = widen(edge_all[g]);
               sev_mask_off(SEV_ERR):   rd_g[g] = widen(sevm[SEV_ERR]);
               sev_mask_off(SEV_ABORT): rd_g[g] = widen(sevm[SEV_ABORT]);
               sev_mask_off(SEV_FATAL): rd_g[g] = widen(sevm[SEV_FATAL]);
               sev_mask_off(SEV_LOG):   rd_g[g] = widen(sevm[SEV_LOG]);
               default:                rd_g[g] = '0;
            endcase
         end
      end
   endgenerate

   always_comb begin
      prdata = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (grp_idx == GIDX_W'(g)) prdata = rd_g[g];
      end
   end

endmodule

// File: rtl/sia_chk.sv
module sia_chk
   import sia_pkg::*;
#(
   parameter int NUM_GRP = 4,
   parameter int GRP_W   = 32,
   parameter int ADDR_W  = 8
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          psel,
   input logic                          penable,
   input logic                          pwrite,
   input logic [ADDR_W-1:0]             paddr,
   input logic [NUM_GRP*GRP_W-1:0]      trig_i,
   input logic [NUM_GRP-1:0]            err_o,
   input logic [NUM_GRP-1:0][GRP_W-1:0] cause_all,
   input logic [NUM_GRP-1:0][GRP_W-1:0] hw_set_all,
   input logic [NUM_GRP-1:0][GRP_W-1:0] sw_set_all,
   input logic [NUM_GRP-1:0][GRP_W-1:0] imask_all,
   input logic [NUM_GRP-1:0][GRP_W-1:0] edge_all,
   input logic [NUM_GRP-1:0][GRP_W-1:0] errmask_all
);

   logic [NUM_GRP*GRP_W-1:0] lvl_fire;
   logic                     cause_wr;

   assign lvl_fire = trig_i & ~edge_all & ~imask_all;
   assign cause_wr = psel && penable && pwrite && (paddr[5:0] == OFF_CAUSE);

   // R2 and R10: a level-mode unmasked high input is set in cause after the edge
   a_r2_level_capture: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_all & $past(lvl_fire)) == $past(lvl_fire)));

   // R6: a cause bit rises only from a hardware or software set
   a_r6_set_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_all & ~$past(cause_all) & ~$past(hw_set_all | sw_set_all)) == '0));

   // R5: a cause bit falls only after a write to the cause register
   a_r5_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(cause_all) & ~cause_all) != '0) |-> $past(cause_wr));

   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
         // R9: error summary follows masked cause with one cycle of delay
         a_r9_err_lag: assert property (@(posedge clk) disable iff (!rst_n)
            err_o[g] == $past(|(cause_all[g] & ~errmask_all[g])));
      end
   endgenerate

endmodule

bind sev_irq_agg sia_chk #(
   .NUM_GRP (NUM_GRP),
   .GRP_W   (GRP_W),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .psel        (psel),
   .penable     (penable),
   .pwrite      (pwrite),
   .paddr       (paddr),
   .trig_i      (trig_i),
   .err_o       (err_o),
   .cause_all   (cause_all),
   .hw_set_all  (hw_set_all),
   .sw_set_all  (sw_set_all),
   .imask_all   (imask_all),
   .edge_all    (edge_all),
   .errmask_all (errmask_all)
);

// File: tb/sev_irq_agg_tb.sv
`timescale 1ns/1ps
module sev_irq_agg_tb_top;

   localparam int NG = 2;
   localparam int GW = 8;
   localparam int AW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [AW-1:0] paddr = '0;
   logic [31:0]   pwdata = '0;
   logic [31:0]   prdata;
   logic [NG*GW-1:0] trig = '0;
   logic [NG-1:0] err_o, abort_o, fatal_o, log_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   sev_irq_agg #(.NUM_GRP(NG), .GRP_W(GW), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .trig_i(trig),
      .err_o(err_o), .abort_o(abort_o), .fatal_o(fatal_o), .log_o(log_o));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] adr(input int g, input int o);
      return AW'(g * 64 + o);
   endfunction

   task automatic wr(input int g, input int o, input logic [31:0] d);
      @(negedge clk);
      psel = 1; pwrite = 1; penable = 0; paddr = adr(g, o); pwdata = d;
      @(negedge clk);
      penable = 1;
      @(negedge clk);
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic rd(input int g, input int o, output logic [31:0] d);
      @(negedge clk);
      psel = 1; pwrite = 0; penable = 0; paddr = adr(g, o);
      @(negedge clk);
      penable = 1;
      d = prdata;
      @(negedge clk);
      psel = 0; penable = 0;
   endtask

   function automatic logic [3:0] sev_vec(input int g);
      return {log_o[g], fatal_o[g], abort_o[g], err_o[g]};
   endfunction

   initial begin
      logic [31:0] d;
      logic [7:0]  exp_c;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset state of both groups
      for (int g = 0; g < NG; g++) begin
         rd(g, 'h00, d); chk("R1 cause", d, 0);
         rd(g, 'h10, d); chk("R1 imask", d, 32'hFF);
         rd(g, 'h28, d); chk("R1 ctrl", d, 32'h1);
         rd(g, 'h3C, d); chk("R1 edge", d, 0);
         for (int s = 0; s < 4; s++) begin
            rd(g, 'h2C + 4*s, d); chk("R1 sevmask", d, 32'hFF);
         end
         chk("R1 outputs", 32'(sev_vec(g)), 0);
      end

      // R4: masked sources do not latch
      trig[7:0] = 8'hFF;
      repeat (4) @(negedge clk);
      rd(0, 'h00, d); chk("R4 masked no capture", d, 0);
      trig = '0;
      @(negedge clk);

      // R7: unmask port clears only zero bits
      wr(0, 'h18, 32'hA5); rd(0, 'h10, d); chk("R7 unmask zeros", d, 32'hA5);
      wr(0, 'h18, 32'hFF); rd(0, 'h10, d); chk("R7 ones keep", d, 32'hA5);
      wr(0, 'h10, 32'h00); rd(0, 'h10, d); chk("R7 direct load", d, 0);

      // R6: inject each bit, accumulating
      exp_c = 0;
      for (int b = 0; b < GW; b++) begin
         wr(0, 'h08, 32'(1 << b));
         exp_c |= 8'(1 << b);
         rd(0, 'h00, d); chk("R6 inject", d, 32'(exp_c));
      end
      wr(0, 'h08, 0); rd(0, 'h00, d); chk("R6 zero inject no effect", d, 32'hFF);
      rd(0, 'h08, d); chk("R12 inject reads zero", d, 0);
      rd(0, 'h18, d); chk("R12 unmask reads zero", d, 0);

      // R5: writing ones keeps, writing zero clears
      wr(0, 'h00, 32'hFF); rd(0, 'h00, d); chk("R5 ones keep", d, 32'hFF);
      for (int b = 0; b < GW; b++) begin
         wr(0, 'h00, 32'(~(1 << b) & 8'hFF));
         exp_c &= ~8'(1 << b);
         rd(0, 'h00, d); chk("R5 zero clears", d, 32'(exp_c));
      end

      // R2: level capture per bit
      for (int b = 0; b < GW; b++) begin
         @(negedge clk); trig[b] = 1;
         @(negedge clk); trig[b] = 0;
         rd(0, 'h00, d); chk("R2 level capture", d, 32'(1 << b));
         wr(0, 'h00, 0);
      end

      // R10: hardware set beats same-edge software clear
      wr(0, 'h2C, 32'hFE);
      @(negedge clk); trig[0] = 1;
      repeat (2) @(negedge clk);
      wr(0, 'h00, 0);
      @(negedge clk);
      chk("R10 hw wins err stays", 32'(err_o[0]), 1);
      trig[0] = 0;
      @(negedge clk);
      wr(0, 'h00, 0);
      wr(0, 'h2C, 32'hFF);
      rd(0, 'h00, d); chk("R10 cleared after drop", d, 0);

      // R3: edge capture
      wr(0, 'h3C, 32'hFF);
      rd(0, 'h3C, d); chk("R3 edge mode set", d, 32'hFF);
      @(negedge clk); trig[3] = 1;
      repeat (2) @(negedge clk);
      rd(0, 'h00, d); chk("R3 rising sets", d, 32'h08);
      wr(0, 'h00, 0);
      repeat (2) @(negedge clk);
      rd(0, 'h00, d); chk("R3 steady high no reset", d, 0);
      trig[3] = 0;
      repeat (2) @(negedge clk);
      trig[3] = 1;
      repeat (2) @(negedge clk);
      rd(0, 'h00, d); chk("R3 second edge sets", d, 32'h08);
      trig[3] = 0;
      @(negedge clk);
      wr(0, 'h00, 0);

      // R8: status shows raw sampled inputs
      for (int b = 0; b < GW; b++) begin
         @(negedge clk); trig[7:0] = 8'(1 << b) ^ 8'h30;
         @(negedge clk);
         rd(0, 'h20, d); chk("R8 status", d, 32'(8'(1 << b) ^ 8'h30));
      end
      trig = '0;
      repeat (2) @(negedge clk);
      wr(0, 'h00, 0);
      wr(0, 'h20, 32'hFF);
      rd(0, 'h20, d); chk("R12 status write ignored", d, 0);

      // R9: severity sweep
      wr(0, 'h08, 32'h5A);
      for (int s = 0; s < 4; s++) begin
         for (int b = 0; b < GW; b++) begin
            wr(0, 'h2C + 4*s, 32'(~(1 << b) & 8'hFF));
            @(negedge clk);
            chk("R9 severity", 32'(sev_vec(0)),
                32'(((32'h5A >> b) & 1) << s));
         end
         wr(0, 'h2C + 4*s, 32'hFF);
         @(negedge clk);
         chk("R9 all masked", 32'(sev_vec(0)), 0);
      end

      // R11: group isolation
      rd(1, 'h00, d); chk("R11 g1 cause untouched", d, 0);
      rd(1, 'h10, d); chk("R11 g1 imask untouched", d, 32'hFF);
      rd(1, 'h3C, d); chk("R11 g1 edge untouched", d, 0);
      wr(1, 'h08, 32'h80);
      wr(1, 'h30, 32'h7F);
      @(negedge clk);
      chk("R11 g1 abort only", 32'(sev_vec(1)), 32'h2);
      chk("R11 g0 quiet", 32'(sev_vec(0)), 0);
      rd(0, 'h00, d); chk("R11 g0 cause kept", d, 32'h5A);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule